// File: doc/BRIEF.md
# Unaligned Access Splitter

This block sits between a load/store execution stage and a data cache port that is one 32-bit word wide. It accepts one scalar access at a time: a byte address, a byte count of 1, 2 or 4, a read/write flag, store data and a flag that marks reservation-type accesses (load-with-reservation and conditional store). It guarantees that the cache port never sees a request whose bytes fall in two different words. When the in-word offset plus the byte count is more than four, the access goes out as two word-contained requests. The first covers the bytes from the start address to the end of its word. The second starts at the next word-aligned address and covers the bytes that remain.

Bytes are numbered big-endian within a word: the byte at in-word offset k travels on data bits [31-8k:24-8k], and byte-enable bit k marks offset k. The store value and the load result are right-justified. Their most significant byte belongs to the lowest address. For a load, the block joins the two returned words into one zero-extended result. The bytes of the first part become the upper bytes of that result. Each access ends with a one-cycle response that carries the data, the number of cache beats used, and an alignment-error flag. A reservation-type access at an address that is not word-aligned is refused with that flag and never reaches the cache.

Top module: `word_access_splitter`

## Requirements
- R1: `req_ready` is high only while no access is in progress. An access is accepted on a clock edge where `req_valid` and `req_ready` are both high. No new access is accepted until the response of the current one has been given. `req_size` codes 0, 1 and 2 mean 1, 2 and 4 bytes, and code 3 is treated as 4 bytes.
- R2: Every cache request has `cq_addr[1:0]` equal to 0 and a non-empty, contiguous `cq_be`, where bit k enables in-word offset k.
- R3: An access is split into two cache requests exactly when `addr[1:0]` plus the byte count is greater than 4. Otherwise exactly one request is sent, to the word that holds the access.
- R4: In a split access, the first request goes to the word that holds the start address, with offsets `addr[1:0]` up to 3 enabled. After that request is accepted, the second request goes to that word address plus 4, with offsets 0 up to the remaining count minus 1 enabled.
- R5: `rsp_cycles` is 1 for an access that is not split and 2 for a split one. With `cq_ready` held high, `rsp_valid` rises on the 2nd clock edge after acceptance for an access that is not split and on the 3rd edge for a split one: exactly one cycle more.
- R6: A reservation-type access (`req_rsv`=1) with `addr[1:0]` not equal to 0 sends no cache request. It responds on the 1st edge after acceptance with `rsp_err`=1, `rsp_cycles`=0 and `rsp_rdata`=0. A word-aligned reservation access is carried out normally with `rsp_err`=0.
- R7: For stores, `cq_write` is 1, and each store byte travels on the lane of its own in-word offset in the request for its word. The most significant of the N store bytes (`req_wdata[8N-1:8N-8]`) is written to the start address.
- R8: For loads, `rsp_rdata` holds the N bytes from the start address upward, right-justified and zero-extended. The byte at the start address is the most significant, so the bytes from the first part sit above those from the second. Read data on `cq_rdata` is taken one cycle after the read request is accepted. For stores, `rsp_rdata` is 0.
- R9: While `cq_valid` is high and `cq_ready` is low, the request stays valid, and its address, byte enables and write data do not change on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Block can accept an access |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | 2 | Byte count code (0:1, 1:2, 2 or 3:4) |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wdata | input | 32 | Store value, right-justified |
| req_rsv | input | 1 | Reservation-type access, must be word-aligned |
| cq_valid | output | 1 | Cache request valid |
| cq_ready | input | 1 | Cache accepts the request |
| cq_addr | output | ADDR_W | Word-aligned cache address |
| cq_be | output | 4 | Byte enables, bit k = in-word offset k |
| cq_write | output | 1 | Cache request is a write |
| cq_wdata | output | 32 | Write data on big-endian byte lanes |
| cq_rdata | input | 32 | Read word, valid one cycle after read acceptance |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 32 | Load result, right-justified |
| rsp_cycles | output | 2 | Cache beats used (0, 1 or 2) |
| rsp_err | output | 1 | Alignment error on a reservation access |

## Verification
A wrong split decision shows at the cache port on the first request of the access. The byte enables or the beat count are then wrong, and a second request either appears or fails to appear one accepted beat later. A latched offset or count that has gone wrong, or a first-part word captured in the wrong cycle, shows up only in the response strobe. That strobe comes two or three cycles after acceptance, as wrong bytes in `rsp_rdata` or a response that comes one edge early or late. A bad store lane shows nothing until the same bytes are loaded back, so the bench also compares the write data on each enabled lane directly, at the beat itself.

// File: rtl/splt_pkg.sv
package splt_pkg;
  localparam int LANE_W     = 8;
  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = LANE_W * WORD_BYTES;
  localparam int PAIR_W     = 2 * WORD_W;
  localparam int OFF_W      = $clog2(WORD_BYTES);
  localparam int CNT_W      = OFF_W + 1;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PART_A = 2'd1,
    ST_PART_B = 2'd2,
    ST_FINISH = 2'd3
  } issue_state_t;

  // size code to byte count; the top code falls back to a full word
  function automatic logic [CNT_W-1:0] bytes_of(input logic [1:0] code);
    case (code)
      2'd0:    return CNT_W'(1);
      2'd1:    return CNT_W'(2);
      default: return CNT_W'(WORD_BYTES);
    endcase
  endfunction

  // enables across a two-word window: bit p = window byte position p
  function automatic logic [2*WORD_BYTES-1:0] lane_mask(input logic [OFF_W-1:0] off,
                                                        input logic [CNT_W-1:0] nb);
    logic [2*WORD_BYTES:0] ones;
    ones = ((2*WORD_BYTES+1)'(1) << nb) - (2*WORD_BYTES+1)'(1);
    return (2*WORD_BYTES)'(ones) << off;
  endfunction

  // right-justified value moved to window positions off..off+nb-1
  function automatic logic [PAIR_W-1:0] place_store(input logic [WORD_W-1:0] v,
                                                    input logic [OFF_W-1:0] off,
                                                    input logic [CNT_W-1:0] nb);
    logic [PAIR_W-1:0] w;
    w = {v, {WORD_W{1'b0}}};
    w = w << (LANE_W * (WORD_BYTES - int'(nb)));
    w = w >> (LANE_W * int'(off));
    return w;
  endfunction

  // window positions off..off+nb-1 brought down to a right-justified value
  function automatic logic [WORD_W-1:0] extract_load(input logic [PAIR_W-1:0] w,
                                                     input logic [OFF_W-1:0] off,
                                                     input logic [CNT_W-1:0] nb);
    logic [PAIR_W-1:0] t;
    t = w << (LANE_W * int'(off));
    t = t >> (PAIR_W - LANE_W * int'(nb));
    return t[WORD_W-1:0];
  endfunction

  function automatic logic be_contiguous(input logic [WORD_BYTES-1:0] be);
    logic [WORD_BYTES:0] low;
    low = {1'b0, be} & ~({1'b0, be} - (WORD_BYTES+1)'(1));
    return (be != '0) && (((({1'b0, be} + low) & {1'b0, be})) == '0);
  endfunction
endpackage

// File: rtl/splt_plan.sv
module splt_plan
  import splt_pkg::*;
(
  input  logic [OFF_W-1:0]      off,
  input  logic [1:0]            size_code,
  input  logic [WORD_W-1:0]     wdata,
  input  logic                  rsv,
  output logic [OFF_W-1:0]      off_o,
  output logic [CNT_W-1:0]      nbytes,
  output logic [WORD_BYTES-1:0] be_a,
  output logic [WORD_BYTES-1:0] be_b,
  output logic                  split,
  output logic [WORD_W-1:0]     wd_a,
  output logic [WORD_W-1:0]     wd_b,
  output logic                  align_err
);
  logic [2*WORD_BYTES-1:0] mask;
  logic [PAIR_W-1:0]       placed;

  always_comb begin
    nbytes = bytes_of(size_code);
    mask   = lane_mask(off, nbytes);
    placed = place_store(wdata, off, nbytes);
  end

  assign off_o     = off;
  assign be_a      = mask[WORD_BYTES-1:0];
  assign be_b      = mask[2*WORD_BYTES-1:WORD_BYTES];
  assign split     = |be_b;
  assign wd_a      = placed[PAIR_W-1:WORD_W];
  assign wd_b      = placed[WORD_W-1:0];
  assign align_err = rsv && (off != '0);
endmodule

// File: rtl/splt_issue.sv
module splt_issue
  import splt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic                  req_write,
  input  logic [OFF_W-1:0]      off_in,
  input  logic [CNT_W-1:0]      nb_in,
  input  logic [WORD_BYTES-1:0] be_a_in,
  input  logic [WORD_BYTES-1:0] be_b_in,
  input  logic                  split_in,
  input  logic [WORD_W-1:0]     wd_a_in,
  input  logic [WORD_W-1:0]     wd_b_in,
  input  logic                  err_in,
  output logic                  cq_valid,
  input  logic                  cq_ready,
  output logic [ADDR_W-1:0]     cq_addr,
  output logic [WORD_BYTES-1:0] cq_be,
  output logic                  cq_write,
  output logic [WORD_W-1:0]     cq_wdata,
  output logic                  cap_first,
  output logic                  resp_evt,
  output logic [OFF_W-1:0]      off_q,
  output logic [CNT_W-1:0]      nb_q,
  output logic                  split_q,
  output logic                  write_q,
  output logic                  err_q
);
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(WORD_BYTES);

  issue_state_t              state_q, state_d;
  logic [ADDR_W-1:0]         base_q;
  logic [WORD_BYTES-1:0]     be_a_q, be_b_q;
  logic [WORD_W-1:0]         wd_a_q, wd_b_q;
  logic                      first_pend_q;

  // named events for the checks below
  logic req_fire, fire_a, fire_a_split, fire_b;
  assign req_fire     = req_valid && req_ready;
  assign fire_a       = (state_q == ST_PART_A) && cq_ready;
  assign fire_a_split = fire_a && split_q;
  assign fire_b       = (state_q == ST_PART_B) && cq_ready;

  assign req_ready = (state_q == ST_IDLE);
  assign resp_evt  = (state_q == ST_FINISH);
  assign cap_first = (state_q == ST_PART_B) && first_pend_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (req_fire) state_d = err_in ? ST_FINISH : ST_PART_A;
      ST_PART_A: if (cq_ready) state_d = split_q ? ST_PART_B : ST_FINISH;
      ST_PART_B: if (cq_ready) state_d = ST_FINISH;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    cq_valid = 1'b0;
    cq_addr  = base_q;
    cq_be    = be_a_q;
    cq_wdata = wd_a_q;
    case (state_q)
      ST_PART_A: cq_valid = 1'b1;
      ST_PART_B: begin
        cq_valid = 1'b1;
        cq_addr  = base_q + WORD_STEP;
        cq_be    = be_b_q;
        cq_wdata = wd_b_q;
      end
      default: ;
    endcase
  end
  assign cq_write = write_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      base_q       <= '0;
      be_a_q       <= '0;
      be_b_q       <= '0;
      wd_a_q       <= '0;
      wd_b_q       <= '0;
      off_q        <= '0;
      nb_q         <= '0;
      split_q      <= 1'b0;
      write_q      <= 1'b0;
      err_q        <= 1'b0;
      first_pend_q <= 1'b0;
    end else begin
      state_q      <= state_d;
      first_pend_q <= fire_a_split && !write_q;
      if (req_fire) begin
        base_q  <= {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        be_a_q  <= be_a_in;
        be_b_q  <= be_b_in;
        wd_a_q  <= wd_a_in;
        wd_b_q  <= wd_b_in;
        off_q   <= off_in;
        nb_q    <= nb_in;
        split_q <= split_in;
        write_q <= req_write;
        err_q   <= err_in;
      end
    end
  end

  // R1: a just-accepted access blocks the next one
  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !req_ready);

  // R2: every beat is word-aligned with contiguous enables
  a_r2_word_contained: assert property (@(posedge clk) disable iff (!rst_n)
    cq_valid |-> (cq_addr[OFF_W-1:0] == '0) && be_contiguous(cq_be));

  // R4: second beat targets the following word right after the first is taken
  a_r4_next_word: assert property (@(posedge clk) disable iff (!rst_n)
    fire_a_split |=> cq_valid && (cq_addr == $past(cq_addr) + WORD_STEP));

  // R6: a refused reservation access puts nothing on the cache port
  a_r6_refuse_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && err_in) |=> !cq_valid);

  // R9: a stalled request holds still
  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (cq_valid && !cq_ready) |=> cq_valid && $stable(cq_addr) && $stable(cq_be)
                                 && $stable(cq_wdata));

  // R3: an unsplit access never issues a second beat
  a_r3_single_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_a && !split_q) |=> !cq_valid);
endmodule

// File: rtl/splt_merge.sv
module splt_merge
  import splt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_first,
  input  logic              resp_evt,
  input  logic [WORD_W-1:0] cq_rdata,
  input  logic [OFF_W-1:0]  off,
  input  logic [CNT_W-1:0]  nb,
  input  logic              split,
  input  logic              write,
  input  logic              err,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic [1:0]        rsp_cycles,
  output logic              rsp_err
);
  logic [WORD_W-1:0] first_q;
  logic [WORD_W-1:0] upper_w, lower_w, joined;

  always_comb begin
    upper_w = split ? first_q : cq_rdata;
    lower_w = split ? cq_rdata : '0;
    joined  = extract_load({upper_w, lower_w}, off, nb);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q    <= '0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      rsp_cycles <= '0;
      rsp_err    <= 1'b0;
    end else begin
      if (cap_first) first_q <= cq_rdata;
      rsp_valid <= resp_evt;
      if (resp_evt) begin
        rsp_err    <= err;
        rsp_cycles <= err ? 2'd0 : (split ? 2'd2 : 2'd1);
        rsp_rdata  <= (err || write) ? '0 : joined;
      end
    end
  end

  // R5: a good access reports one or two beats
  a_r5_beat_count: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_err) |-> (rsp_cycles == 2'd1 || rsp_cycles == 2'd2));

  // R6: a refused access reports no beats and no data
  a_r6_err_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_cycles == 2'd0) && (rsp_rdata == '0));

  // R5: the response is a single-cycle strobe
  a_r5_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/word_access_splitter.sv
module word_access_splitter
  import splt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [1:0]            req_size,
  input  logic                  req_write,
  input  logic [WORD_W-1:0]     req_wdata,
  input  logic                  req_rsv,
  output logic                  cq_valid,
  input  logic                  cq_ready,
  output logic [ADDR_W-1:0]     cq_addr,
  output logic [WORD_BYTES-1:0] cq_be,
  output logic                  cq_write,
  output logic [WORD_W-1:0]     cq_wdata,
  input  logic [WORD_W-1:0]     cq_rdata,
  output logic                  rsp_valid,
  output logic [WORD_W-1:0]     rsp_rdata,
  output logic [1:0]            rsp_cycles,
  output logic                  rsp_err
);
  logic [OFF_W-1:0]      p_off, off_q;
  logic [CNT_W-1:0]      p_nb, nb_q;
  logic [WORD_BYTES-1:0] p_be_a, p_be_b;
  logic                  p_split, p_err;
  logic [WORD_W-1:0]     p_wd_a, p_wd_b;
  logic                  cap_first, resp_evt, split_q, write_q, err_q;

  splt_plan u_plan (
    .off       (req_addr[OFF_W-1:0]),
    .size_code (req_size),
    .wdata     (req_wdata),
    .rsv       (req_rsv),
    .off_o     (p_off),
    .nbytes    (p_nb),
    .be_a      (p_be_a),
    .be_b      (p_be_b),
    .split     (p_split),
    .wd_a      (p_wd_a),
    .wd_b      (p_wd_b),
    .align_err (p_err)
  );

  splt_issue #(.ADDR_W(ADDR_W)) u_issue (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_write (req_write),
    .off_in    (p_off),
    .nb_in     (p_nb),
    .be_a_in   (p_be_a),
    .be_b_in   (p_be_b),
    .split_in  (p_split),
    .wd_a_in   (p_wd_a),
    .wd_b_in   (p_wd_b),
    .err_in    (p_err),
    .cq_valid  (cq_valid),
    .cq_ready  (cq_ready),
    .cq_addr   (cq_addr),
    .cq_be     (cq_be),
    .cq_write  (cq_write),
    .cq_wdata  (cq_wdata),
    .cap_first (cap_first),
    .resp_evt  (resp_evt),
    .off_q     (off_q),
    .nb_q      (nb_q),
    .split_q   (split_q),
    .write_q   (write_q),
    .err_q     (err_q)
  );

  splt_merge u_merge (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_first  (cap_first),
    .resp_evt   (resp_evt),
    .cq_rdata   (cq_rdata),
    .off        (off_q),
    .nb         (nb_q),
    .split      (split_q),
    .write      (write_q),
    .err        (err_q),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .rsp_cycles (rsp_cycles),
    .rsp_err    (rsp_err)
  );
endmodule

// File: tb/word_access_splitter_bench.sv
module word_access_splitter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        req_rsv = 1'b0;
  logic        cq_valid;
  logic        cq_ready = 1'b1;
  logic [31:0] cq_addr;
  logic [3:0]  cq_be;
  logic        cq_write;
  logic [31:0] cq_wdata;
  logic [31:0] cq_rdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [1:0]  rsp_cycles;
  logic        rsp_err;

  int checks = 0;
  int errors = 0;
  bit stall_en = 1'b0;

  always #10 clk = ~clk;

  word_access_splitter #(.ADDR_W(32)) u_word_access_splitter (.*);

  // cache model: 16 words, big-endian lanes
  logic [31:0] cmem [16];
  logic [7:0]  exp_b [64];
  int          mon_n = 0;
  logic [31:0] log_addr [2];
  logic [3:0]  log_be [2];
  logic [31:0] log_wd [2];
  logic        log_wr [2];
  bit          prev_stall = 1'b0;
  logic [31:0] prev_addr;
  logic [3:0]  prev_be;
  logic [31:0] prev_wd;
  int          hold_bad = 0;

  always @(negedge clk) cq_ready <= stall_en ? (($urandom % 3) != 0) : 1'b1;

  always @(posedge clk) begin
    if (prev_stall && (!cq_valid || cq_addr != prev_addr || cq_be != prev_be ||
                       cq_wdata != prev_wd))
      hold_bad <= hold_bad + 1;
    prev_stall <= cq_valid && !cq_ready;
    prev_addr  <= cq_addr;
    prev_be    <= cq_be;
    prev_wd    <= cq_wdata;
    if (cq_valid && cq_ready) begin
      if (mon_n < 2) begin
        log_addr[mon_n] <= cq_addr;
        log_be[mon_n]   <= cq_be;
        log_wd[mon_n]   <= cq_wdata;
        log_wr[mon_n]   <= cq_write;
      end
      mon_n <= mon_n + 1;
      if (cq_write) begin
        for (int k = 0; k < 4; k++)
          if (cq_be[k]) cmem[cq_addr[5:2]][8*(3-k) +: 8] <= cq_wdata[8*(3-k) +: 8];
      end else begin
        cq_rdata <= cmem[cq_addr[5:2]];
      end
    end
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] lane_bits(input logic [3:0] be);
    logic [31:0] m = '0;
    for (int k = 0; k < 4; k++) if (be[k]) m[8*(3-k) +: 8] = 8'hFF;
    return m;
  endfunction

  task automatic run_access(input logic [31:0] a, input logic [1:0] sz, input logic wr,
                            input logic [31:0] v, input logic rsv, input bit timed);
    int          nb, lat, nbeats;
    bit          err, busy_bad;
    logic [3:0]  ebe [2];
    logic [31:0] ewd [2];
    logic [31:0] eload, ab;
    nb  = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    err = rsv && (a[1:0] != 2'b00);
    ebe[0] = '0; ebe[1] = '0; ewd[0] = '0; ewd[1] = '0; eload = '0;
    for (int j = 0; j < nb; j++) begin
      int part;
      ab   = a + 32'(j);
      part = ((ab >> 2) == (a >> 2)) ? 0 : 1;
      ebe[part][ab[1:0]] = 1'b1;
      ewd[part][8*(3-int'(ab[1:0])) +: 8] = v[8*(nb-1-j) +: 8];
      eload = (eload << 8) | 32'(exp_b[ab[5:0]]);
    end
    nbeats = err ? 0 : ((ebe[1] != 0) ? 2 : 1);

    @(negedge clk);
    mon_n     = 0;
    req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr;
    req_wdata = v;    req_rsv  = rsv;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1; busy_bad = 1'b0;
    while (!rsp_valid) begin
      if (req_ready) busy_bad = 1'b1;
      @(negedge clk);
      lat++;
    end

    chk(!busy_bad, "R1 ready low while busy", 32'(busy_bad), 0);
    chk(rsp_err == err, "R6 alignment error flag", 32'(rsp_err), 32'(err));
    chk(rsp_cycles == 2'(nbeats), "R5 reported beats", 32'(rsp_cycles), 32'(nbeats));
    chk(mon_n == nbeats, "R3 beats on cache port", 32'(mon_n), 32'(nbeats));
    if (timed)
      chk(lat == nbeats + 2, "R5 response latency", 32'(lat), 32'(nbeats + 2));
    if (!err && mon_n == nbeats) begin
      for (int p = 0; p < nbeats; p++) begin
        logic [31:0] ea;
        ea = {a[31:2], 2'b00} + 32'(4 * p);
        chk(log_addr[p] == ea, "R4 beat address", log_addr[p], ea);
        chk(log_be[p] == ebe[p], "R2 beat byte enables", 32'(log_be[p]), 32'(ebe[p]));
        chk(log_wr[p] == wr, "R7 beat write flag", 32'(log_wr[p]), 32'(wr));
        if (wr)
          chk((log_wd[p] & lane_bits(ebe[p])) == ewd[p], "R7 store lanes",
              log_wd[p] & lane_bits(ebe[p]), ewd[p]);
      end
    end
    if (err || wr)
      chk(rsp_rdata == 0, "R8 no load data", rsp_rdata, 0);
    else
      chk(rsp_rdata == eload, "R8 load result", rsp_rdata, eload);
    if (wr && !err)
      for (int j = 0; j < nb; j++) begin
        ab = a + 32'(j);
        exp_b[ab[5:0]] = v[8*(nb-1-j) +: 8];
      end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) exp_b[i] = 8'(i * 37 + 5);
    for (int w = 0; w < 16; w++)
      cmem[w] = {exp_b[4*w], exp_b[4*w+1], exp_b[4*w+2], exp_b[4*w+3]};
    void'($urandom(32'd1357));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 1);
    chk(cq_valid == 1'b0, "R2 no beat after reset", 32'(cq_valid), 0);
    chk(rsp_valid == 1'b0, "R5 no response after reset", 32'(rsp_valid), 0);

    // directed corners, no stalls
    run_access(32'h0000_0103, 2'd2, 1'b0, 0, 1'b0, 1'b1); // R3 word at offset 3: 1 + 3
    run_access(32'h0000_0110, 2'd2, 1'b0, 0, 1'b0, 1'b1); // R3 aligned word
    run_access(32'h0000_0127, 2'd1, 1'b0, 0, 1'b0, 1'b1); // R4 half at offset 3: 1 + 1
    run_access(32'h0000_0132, 2'd1, 1'b0, 0, 1'b0, 1'b1); // R3 half at offset 2: no split
    run_access(32'h0000_0143, 2'd0, 1'b0, 0, 1'b0, 1'b1); // R3 byte at offset 3
    run_access(32'h0000_0105, 2'd2, 1'b1, 32'hA1B2C3D4, 1'b0, 1'b1); // R7 split store
    run_access(32'h0000_0105, 2'd2, 1'b0, 0, 1'b0, 1'b1); // R8 read it back
    run_access(32'h0000_0106, 2'd1, 1'b0, 0, 1'b0, 1'b1); // R8 partial read back
    run_access(32'h0000_0102, 2'd2, 1'b0, 0, 1'b1, 1'b1); // R6 unaligned reservation
    run_access(32'h0000_0101, 2'd2, 1'b1, 32'h1111_2222, 1'b1, 1'b1); // R6 refused store
    run_access(32'h0000_0100, 2'd2, 1'b0, 0, 1'b0, 1'b1); // R6 nothing was written
    run_access(32'h0000_0108, 2'd2, 1'b1, 32'h5566_7788, 1'b1, 1'b1); // R6 aligned reservation
    run_access(32'h0000_0109, 2'd3, 1'b0, 0, 1'b0, 1'b1); // R1 size code 3 as a word
    run_access(32'h0000_013F, 2'd2, 1'b1, 32'hCAFE_F00D, 1'b0, 1'b1); // R4 wrap in model

    // random traffic, first without and then with cache stalls
    for (int n = 0; n < 600; n++) begin
      logic [31:0] ra;
      ra       = $urandom;
      stall_en = (n >= 300);
      run_access(ra, 2'($urandom % 4), 1'($urandom % 2), $urandom,
                 (($urandom % 8) == 0), !stall_en);
    end
    stall_en = 1'b0;
    chk(hold_bad == 0, "R9 stalled beat held", 32'(hold_bad), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule